// File: doc/BRIEF.md
# SPI Pixel Frame Sender

This block is an SPI master that pushes frames of 24-bit colour pixels to an external LED-strip bridge. A frame begins with a one-cycle start pulse that carries a run-time pixel count. The block then waits until the bridge reports it is idle, which it does by driving its ready line low. Pixels arrive one at a time on a valid/ready stream. Each pixel goes out as its own chip-select-framed 32-bit word, and a fixed synchronisation word closes the frame. On that word the bridge latches the buffered pixels onto the strip and clears its buffer.

At start-up the block also sequences the bridge's active-low reset: it holds the reset low for a set number of clocks, releases it, and waits a settle interval. Start requests are ignored until that interval has run out. The serial clock comes from the system clock through an even divider.

Top module: `pxl_spi_sender`

## Requirements
- R1: SPI mode 0 is used: `sck` is low whenever `cs_n` is high, `mosi` changes only on a falling `sck` edge, and it holds steady while `sck` is high.
- R2: Each word is exactly 32 rising `sck` edges long, sent most significant bit first.
- R3: A pixel on `pix_data` has red in bits 23:16, green in 15:8 and blue in 7:0. It is sent as the word {8'h00, green, red, blue}.
- R4: After the last pixel of a frame, one word 32'hDEADBEAF is sent.
- R5: After a start, no word is sent while `per_ready` is high. The frame begins once `per_ready` reads low.
- R6: After `rst`, `per_rst_n` is low for exactly HOLD_CYC clocks and then stays high. Frame starts are ignored until a further SETTLE_CYC clocks have passed.
- R7: `pix_count` is sampled with the start pulse. A count of zero sends only the sync word, and a count above MAX_PIX is limited to MAX_PIX pixels.
- R8: Between any two words, `cs_n` stays high for at least GAP_SCK serial clock periods.
- R9: `pix_ready` is high only while an active frame waits for its next pixel. A pixel is taken only on a cycle where `pix_valid` and `pix_ready` are both high.
- R10: `frame_done` pulses high for one clock, one clock after `cs_n` rises at the end of the sync word.
- R11: One `sck` period lasts CLK_DIV system clocks, half high and half low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle request to send a frame |
| pix_count | input | CNT_W | Pixels in the frame, sampled with frame_start |
| pix_data | input | 24 | Pixel colour, red/green/blue high to low |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready |
| per_ready | input | 1 | Bridge status, low when idle and empty |
| per_rst_n | output | 1 | Active-low reset to the bridge |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the bridge |
| cs_n | output | 1 | Active-low chip select |
| frame_done | output | 1 | One-cycle pulse after the sync word ends |

## Verification
A wrong bit counter or a wrong shift register corrupts the word the bridge receives. The scoreboard sees that at the first `cs_n` rise after the fault, because each captured word is compared with its expected value. A frame controller that loses its remaining-pixel count shows up as an extra or missing word, or as the sync word arriving early, all within the same frame. Divider or gap-counter faults change the measured `sck` period or the chip-select gap on the very next word. A wrong reset-sequencer count moves the `per_rst_n` rising edge away from the exact clock the bench expects.

// File: rtl/pxl_spi_pkg.sv
package pxl_spi_pkg;
  localparam logic [31:0] SYNC_WORD = 32'hDEAD_BEAF;

  typedef enum logic [2:0] {
    F_INIT, F_IDLE, F_WAITRDY, F_FETCH, F_SEND, F_SYNC, F_SYNCW
  } frame_st_t;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} shift_st_t;

  // red[23:16] green[15:8] blue[7:0] -> pad, green, red, blue
  function automatic logic [31:0] pack_pixel(input logic [23:0] rgb);
    return {8'h00, rgb[15:8], rgb[23:16], rgb[7:0]};
  endfunction
endpackage

// File: rtl/pxl_rst_seq.sv
module pxl_rst_seq #(
  parameter int HOLD_CYC   = 2400,
  parameter int SETTLE_CYC = 12000,
  localparam int MAXC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic per_rst_n,
  output logic init_done
);
  logic [CW-1:0] cnt;
  logic          settling;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_rst_n <= 1'b0;
      init_done <= 1'b0;
      settling  <= 1'b0;
      cnt       <= '0;
    end else if (!init_done) begin
      if (!settling) begin
        if (cnt == CW'(HOLD_CYC - 1)) begin
          per_rst_n <= 1'b1;
          settling  <= 1'b1;
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (cnt == CW'(SETTLE_CYC - 1)) begin
        init_done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_hold_before_init_r6: assert property (@(posedge clk) disable iff (rst)
    !per_rst_n |-> !init_done);
  p_release_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    per_rst_n |=> per_rst_n);
endmodule

// File: rtl/pxl_spi_shifter.sv
module pxl_spi_shifter
  import pxl_spi_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int GAP_SCK = 2,
  parameter int WORD_W  = 32,
  localparam int HALF     = CLK_DIV / 2,
  localparam int HW       = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int GAP_CLKS = GAP_SCK * CLK_DIV,
  localparam int GW       = $clog2(GAP_CLKS + 1),
  localparam int BW       = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              idle,
  output logic              word_end,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n
);
  shift_st_t         st;
  logic [HW-1:0]     hcnt;
  logic [BW-1:0]     bcnt;
  logic [GW-1:0]     gcnt;
  logic [WORD_W-1:0] shreg;
  logic              gap_seen;

  assign idle = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      cs_n     <= 1'b1;
      hcnt     <= '0;
      bcnt     <= '0;
      gcnt     <= '0;
      shreg    <= '0;
      word_end <= 1'b0;
      gap_seen <= 1'b1;
    end else begin
      word_end <= 1'b0;
      case (st)
        S_IDLE: begin
          if (load) begin
            shreg    <= word;
            mosi     <= word[WORD_W-1];
            cs_n     <= 1'b0;
            hcnt     <= '0;
            bcnt     <= '0;
            gap_seen <= 1'b0;
            st       <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (hcnt == HW'(HALF - 1)) begin
            hcnt <= '0;
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              if (bcnt == BW'(WORD_W - 1)) begin
                cs_n     <= 1'b1;
                word_end <= 1'b1;
                gcnt     <= '0;
                st       <= S_GAP;
              end else begin
                bcnt  <= bcnt + 1'b1;
                shreg <= {shreg[WORD_W-2:0], 1'b0};
                mosi  <= shreg[WORD_W-2];
              end
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        S_GAP: begin
          if (gcnt == GW'(GAP_CLKS - 1)) begin
            gap_seen <= 1'b1;
            st       <= S_IDLE;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sck_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  p_mosi_steady_r1: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));
  p_cs_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(gap_seen));
endmodule

// File: rtl/pxl_spi_sender.sv
module pxl_spi_sender
  import pxl_spi_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int GAP_SCK    = 2,
  parameter int MAX_PIX    = 1024,
  parameter int HOLD_CYC   = 2400,
  parameter int SETTLE_CYC = 12000,
  localparam int CNT_W = $clog2(MAX_PIX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] pix_count,
  input  logic [23:0]      pix_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic             per_ready,
  output logic             per_rst_n,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic             frame_done
);
  frame_st_t        st;
  logic [CNT_W-1:0] rem;
  logic             init_done;
  logic             sh_idle, sh_end, sh_load;
  logic [31:0]      sh_word;

  pxl_rst_seq #(.HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC)) u_rst (
    .clk(clk), .rst(rst), .per_rst_n(per_rst_n), .init_done(init_done)
  );

  assign pix_ready = (st == F_FETCH) && (rem != '0);
  assign sh_load   = (pix_valid && pix_ready) || (st == F_SYNC);
  assign sh_word   = (st == F_SYNC) ? SYNC_WORD : pack_pixel(pix_data);

  pxl_spi_shifter #(.CLK_DIV(CLK_DIV), .GAP_SCK(GAP_SCK), .WORD_W(32)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .word(sh_word),
    .idle(sh_idle), .word_end(sh_end),
    .sck(sck), .mosi(mosi), .cs_n(cs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= F_INIT;
      rem        <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        F_INIT:    if (init_done) st <= F_IDLE;
        F_IDLE: begin
          if (frame_start) begin
            rem <= (pix_count > CNT_W'(MAX_PIX)) ? CNT_W'(MAX_PIX) : pix_count;
            st  <= F_WAITRDY;
          end
        end
        F_WAITRDY: if (!per_ready && sh_idle) st <= F_FETCH;
        F_FETCH: begin
          if (rem == '0) begin
            st <= F_SYNC;
          end else if (pix_valid) begin
            rem <= rem - 1'b1;
            st  <= F_SEND;
          end
        end
        F_SEND:    if (sh_idle) st <= F_FETCH;
        F_SYNC:    st <= F_SYNCW;
        F_SYNCW: begin
          if (sh_end) begin
            frame_done <= 1'b1;
            st         <= F_IDLE;
          end
        end
        default:   st <= F_INIT;
      endcase
    end
  end

  p_ready_no_word_r9: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> cs_n);
  p_quiet_in_init_r6: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (cs_n && !pix_ready));
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  p_done_after_cs_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (cs_n && $past(cs_n)));
endmodule

// File: tb/tb_pxl_spi_sender.sv
`timescale 1ns/1ps
module tb_pxl_spi_sender;
  localparam int CLK_DIV = 4, GAP_SCK = 2, MAX_PIX = 64, HOLD = 20, SETTLE = 30;
  localparam int CNT_W = $clog2(MAX_PIX + 1);
  localparam logic [31:0] SYNC = 32'hDEAD_BEAF;

  logic clk = 0, rst = 1, frame_start = 0, pix_valid = 0, per_ready = 0;
  logic [CNT_W-1:0] pix_count = '0;
  logic [23:0] pix_data = '0;
  logic pix_ready, per_rst_n, sck, mosi, cs_n, frame_done;

  always #4 clk = ~clk;

  pxl_spi_sender #(.CLK_DIV(CLK_DIV), .GAP_SCK(GAP_SCK), .MAX_PIX(MAX_PIX),
    .HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .pix_count(pix_count),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .per_ready(per_ready), .per_rst_n(per_rst_n), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .frame_done(frame_done));

  int checks = 0, fails = 0, words_seen = 0, dones = 0, cyc = 0;
  logic [31:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: rebuilds each word from the pins and pops the scoreboard
  logic prev_cs = 1, prev_sck = 0;
  logic [31:0] shw;
  int bits = 0, last_rise = 0, rise_cyc = 0, cs_rise_cyc = -1000, done_phase = 0;
  always @(negedge clk) begin
    cyc++;
    if (done_phase == 1) begin
      check(frame_done === 1'b1, "R10", "done pulse", {31'd0, frame_done}, 1);
      if (frame_done === 1'b1) dones++;
      done_phase = 2;
    end else if (done_phase == 2) begin
      check(frame_done === 1'b0, "R10", "done width", {31'd0, frame_done}, 0);
      done_phase = 0;
    end else if (frame_done !== 1'b0 && !rst) begin
      check(0, "R10", "stray done", {31'd0, frame_done}, 0);
    end
    if (prev_cs && !cs_n) begin
      bits = 0; shw = '0; last_rise = -1;
      check(cyc - cs_rise_cyc >= GAP_SCK * CLK_DIV, "R8", "cs high gap",
            cyc - cs_rise_cyc, GAP_SCK * CLK_DIV);
    end
    if (!cs_n && sck && !prev_sck) begin
      shw = {shw[30:0], mosi};
      bits++;
      if (bits == 2)
        check(cyc - rise_cyc == CLK_DIV, "R11", "sck period", cyc - rise_cyc, CLK_DIV);
      rise_cyc = cyc;
    end
    if (!prev_cs && cs_n) begin
      cs_rise_cyc = cyc;
      words_seen++;
      check(sck === 1'b0, "R1", "sck idle at cs rise", {31'd0, sck}, 0);
      check(bits == 32, "R2", "sck edges per word", bits, 32);
      if (exp_q.size() == 0) begin
        check(0, "R5", "unexpected word", shw, 0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(shw == e, (e == SYNC) ? "R4" : "R3", "word content", shw, e);
        if (e == SYNC) begin
          check(frame_done === 1'b0, "R10", "done not early", {31'd0, frame_done}, 0);
          done_phase = 1;
        end
      end
    end
    if (cs_n) check_quiet_sck();
    prev_cs = cs_n; prev_sck = sck;
  end

  int sck_bad = 0;
  task automatic check_quiet_sck();
    if (sck !== 1'b0 && sck_bad == 0) begin
      sck_bad = 1;
      check(0, "R1", "sck high with cs high", {31'd0, sck}, 0);
    end
  endtask

  function automatic logic [23:0] mkpix(int i, int seed);
    return {8'(i * 37 + seed), 8'(i * 91 + 3), 8'(i * 13 + seed * 5)};
  endfunction

  task automatic push_frame(int n, int seed);
    int m;
    m = (n > MAX_PIX) ? MAX_PIX : n;
    for (int i = 0; i < m; i++) begin
      logic [23:0] p;
      p = mkpix(i, seed);
      exp_q.push_back({8'h00, p[15:8], p[23:16], p[7:0]});
    end
    exp_q.push_back(SYNC);
  endtask

  task automatic pulse_start(int n);
    @(negedge clk);
    pix_count = CNT_W'(n);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic feed(int n, int seed, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        pix_valid = 0;
        while (!pix_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        // R9: no pixel taken while valid is low
        check(cs_n === 1'b1 && pix_ready === 1'b1, "R9", "held without valid",
              {30'd0, cs_n, pix_ready}, 32'd3);
      end
      pix_valid = 1;
      pix_data = mkpix(i, seed);
      while (!pix_ready) @(negedge clk);
      @(negedge clk);
      pix_valid = 0;
      pix_data = 24'hxxxxxx;
    end
  endtask

  task automatic wait_done(int target);
    while (dones < target) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "R2", "watchdog expired", 0, 1);
    finish_sim();
  end

  int rise_at = -1, start_cyc = 0;
  initial begin
    repeat (3) @(negedge clk);
    check(cs_n === 1 && sck === 0 && pix_ready === 0 && frame_done === 0,
          "R6", "reset outputs", {28'd0, cs_n, sck, pix_ready, frame_done}, 32'h8);
    check(per_rst_n === 1'b0, "R6", "bridge reset low", {31'd0, per_rst_n}, 0);
    rst = 0;
    start_cyc = cyc;
    // start request during init must be ignored (R6)
    @(negedge clk); @(negedge clk);
    pix_count = 3; frame_start = 1;
    @(negedge clk); frame_start = 0;
    while (per_rst_n !== 1'b1 && cyc - start_cyc < 200) @(negedge clk);
    rise_at = cyc - start_cyc;
    check(rise_at == HOLD, "R6", "reset hold length", rise_at, HOLD);
    repeat (SETTLE + 20) @(negedge clk);
    check(words_seen == 0 && cs_n === 1 && pix_ready === 0, "R6",
          "start during init ignored", words_seen, 0);

    // plain frame, three pixels
    push_frame(3, 1); pulse_start(3); feed(3, 1, 0); wait_done(1);
    check(words_seen == 4, "R4", "words in 3-pixel frame", words_seen, 4);

    // zero-length frame: sync only (R7)
    push_frame(0, 0); pulse_start(0); wait_done(2);
    check(words_seen == 5, "R7", "zero frame sends only sync", words_seen, 5);

    // bridge busy: frame held off until ready goes low (R5)
    per_ready = 1;
    push_frame(2, 7); pulse_start(2);
    repeat (200) @(negedge clk);
    check(words_seen == 5 && pix_ready === 0, "R5", "held while busy", words_seen, 5);
    per_ready = 0;
    feed(2, 7, 0); wait_done(3);
    check(words_seen == 8, "R5", "frame after ready low", words_seen, 8);

    // valid gaps (R9)
    push_frame(7, 3); pulse_start(7); feed(7, 3, 1); wait_done(4);
    check(pix_ready === 0, "R9", "ready low between frames", {31'd0, pix_ready}, 0);

    // typical length, then oversize count clamped (R7)
    push_frame(60, 9); pulse_start(60); feed(60, 9, 0); wait_done(5);
    push_frame(70, 4); pulse_start(70); feed(MAX_PIX, 4, 0); wait_done(6);
    check(words_seen == 16 + 61 + 65, "R7", "oversize clamp word total",
          words_seen, 16 + 61 + 65);
    check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    check(dones == 6, "R10", "done count", dones, 6);
    finish_sim();
  end
endmodule